// File: doc/BRIEF.md
# Paired-Register Integer Register File

This block is an integer register file of thirty-two general registers that also feeds floating-point instructions which keep their operands in integer registers rather than in a separate floating-point file. Two combinational read ports and one clocked write port each carry a register index and a width code. A single-width access behaves as an ordinary register access. A double- or quad-width access gathers a wide operand from a group of consecutive registers, or scatters a wide result across such a group. The lowest index in the group always holds the least significant word, whatever the memory byte order.

The register width is a parameter, `XLEN`, of 32 or 64. On a 32-bit file a double operand spans an even-aligned pair and a quad operand spans a group of four starting at a multiple of four. On a 64-bit file a double operand is one register and a quad operand spans an even-aligned pair. A start index that breaks these rules, or the reserved width code, raises a per-port alignment flag in the same cycle. A flagged write leaves the file untouched. A wide write whose group starts at register zero is dropped for the whole group.

Top module: `rfp_regfile`

## Requirements
- R1: Width code 0 selects a single register. The read returns that register in bits XLEN-1:0 and zero above. A write commits on the rising clock edge when `we_i` is high. A read in the same cycle as a write to the same register returns the old value.
- R2: Register 0 always reads zero. A single-width write to index 0 has no effect.
- R3: With XLEN=32, width code 1 (double) at an even index returns the lower-numbered register in bits 31:0 and the next register in bits 63:32. A double write splits its data the same way.
- R4: An odd index with width code 1 on a 32-bit file raises the port's alignment flag. A read that is flagged returns all zeros.
- R5: With XLEN=32, width code 2 (quad) needs an index that is a multiple of 4. Word k of the 128-bit operand (bits 32k+31:32k) maps to register index+k. Any other index raises the flag.
- R6: A wide read that starts at index 0 returns zero in its lowest word and the real contents of the higher registers in its upper words.
- R7: A wide write whose group starts at index 0 changes no register, including register 1.
- R8: A write whose alignment flag is raised changes no register. The flag depends only on the write index and width code, and is valid in the same cycle.
- R9: Width code 3 is reserved. It raises the alignment flag on any port, at any index.
- R10: With XLEN=64, width code 1 is a single 64-bit register at any index. Width code 2 uses an even-aligned pair, with the lower register in bits 63:0 and an odd index flagged.
- R11: The active-low asynchronous reset `rst_ni` clears every register to zero.
- R12: Both read ports follow R1 to R10 independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ra_idx_i | input | 5 | Read port A start index |
| ra_wid_i | input | 2 | Read port A width code |
| ra_data_o | output | 128 | Read port A operand, zero-extended |
| ra_misalign_o | output | 1 | Read port A alignment flag |
| rb_idx_i | input | 5 | Read port B start index |
| rb_wid_i | input | 2 | Read port B width code |
| rb_data_o | output | 128 | Read port B operand, zero-extended |
| rb_misalign_o | output | 1 | Read port B alignment flag |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write start index |
| wr_wid_i | input | 2 | Write width code |
| wr_data_i | input | 128 | Write operand, least significant word first |
| wr_misalign_o | output | 1 | Write alignment flag |

## Verification
The bench builds two copies side by side, one with XLEN=32 and one with XLEN=64, and drives both with the same stimulus. The 32-bit copy covers pair and quad grouping and the multiple-of-four rule, including groups that end at register 31. The 64-bit copy shows that a double becomes a single register and a quad becomes an even pair, so the same index and width code can be legal on one build and flagged on the other. Register-zero suppression is checked on both widths.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int OP_W = 128;

  typedef enum logic [1:0] {
    WID_SGL  = 2'd0,
    WID_DBL  = 2'd1,
    WID_QUAD = 2'd2,
    WID_RSV  = 2'd3
  } wid_e;
endpackage

// File: rtl/rfp_align_chk.sv
module rfp_align_chk
  import rfp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       wid_i,
  output logic [2:0]       span_o,
  output logic             illegal_o
);
  localparam int DBL_N  = (XLEN >= 64)  ? 1 : 64 / XLEN;
  localparam int QUAD_N = (XLEN >= 128) ? 1 : OP_W / XLEN;

  logic [IDX_W-1:0] mask;

  always_comb begin
    unique case (wid_e'(wid_i))
      WID_SGL:  span_o = 3'd1;
      WID_DBL:  span_o = 3'(DBL_N);
      WID_QUAD: span_o = 3'(QUAD_N);
      default:  span_o = 3'd0;
    endcase
    mask      = (span_o == 3'd0) ? '0 : IDX_W'(span_o - 3'd1);
    // span is a power of two, so alignment is a mask test
    illegal_o = (span_o == 3'd0) || ((idx_i & mask) != '0);
  end
endmodule

// File: rtl/rfp_read_port.sv
module rfp_read_port
  import rfp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int IDX_W = 5
) (
  input  logic [NREGS*XLEN-1:0] rf_flat_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [1:0]            wid_i,
  output logic [OP_W-1:0]       data_o,
  output logic                  misalign_o
);
  localparam int MAXW = OP_W / XLEN;

  logic [2:0] span;
  logic       illegal;

  rfp_align_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) align_i (
    .idx_i     (idx_i),
    .wid_i     (wid_i),
    .span_o    (span),
    .illegal_o (illegal)
  );

  assign misalign_o = illegal;

  for (genvar k = 0; k < MAXW; k++) begin : g_word
    logic [IDX_W-1:0] widx;
    assign widx = idx_i + IDX_W'(k);
    assign data_o[k*XLEN +: XLEN] = (!illegal && (3'(k) < span))
                                    ? rf_flat_i[int'(widx)*XLEN +: XLEN] : '0;
  end
endmodule

// File: rtl/rfp_write_dec.sv
module rfp_write_dec
  import rfp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int IDX_W = 5
) (
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [1:0]            wid_i,
  input  logic [OP_W-1:0]       data_i,
  output logic [NREGS-1:1]      wen_o,
  output logic [NREGS*XLEN-1:XLEN] wdat_o,
  output logic                  misalign_o
);
  localparam int MAXW = OP_W / XLEN;

  logic [2:0] span;
  logic       illegal;
  logic       zero_grp;
  logic       commit;

  rfp_align_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) align_i (
    .idx_i     (idx_i),
    .wid_i     (wid_i),
    .span_o    (span),
    .illegal_o (illegal)
  );

  assign misalign_o = illegal;
  // a multi-register group based at x0 is dropped whole
  assign zero_grp   = (idx_i == '0) && (span > 3'd1);
  assign commit     = we_i && !illegal && !zero_grp;

  for (genvar r = 1; r < NREGS; r++) begin : g_reg
    logic [IDX_W-1:0] off;
    logic [XLEN-1:0]  wd;

    assign off      = IDX_W'(r) - idx_i;
    assign wen_o[r] = commit && (off < IDX_W'(span));

    always_comb begin
      wd = '0;
      for (int k = 0; k < MAXW; k++) begin
        if (off == IDX_W'(k)) wd = data_i[k*XLEN +: XLEN];
      end
    end

    assign wdat_o[r*XLEN +: XLEN] = wd;
  end
endmodule

// File: rtl/rfp_regfile.sv
module rfp_regfile
  import rfp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   ra_idx_i,
  input  logic [1:0]         ra_wid_i,
  output logic [OP_W-1:0]    ra_data_o,
  output logic               ra_misalign_o,
  input  logic [IDX_W-1:0]   rb_idx_i,
  input  logic [1:0]         rb_wid_i,
  output logic [OP_W-1:0]    rb_data_o,
  output logic               rb_misalign_o,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [1:0]         wr_wid_i,
  input  logic [OP_W-1:0]    wr_data_i,
  output logic               wr_misalign_o
);
  logic [NREGS*XLEN-1:0]    rf_flat;
  logic [NREGS-1:1]         wen;
  logic [NREGS*XLEN-1:XLEN] wdat;

  rfp_write_dec #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) wdec_i (
    .we_i       (we_i),
    .idx_i      (wr_idx_i),
    .wid_i      (wr_wid_i),
    .data_i     (wr_data_i),
    .wen_o      (wen),
    .wdat_o     (wdat),
    .misalign_o (wr_misalign_o)
  );

  for (genvar r = 0; r < NREGS; r++) begin : g_rf
    if (r == 0) begin : g_zero
      assign rf_flat[XLEN-1:0] = '0;
    end else begin : g_q
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (wen[r]) q <= wdat[r*XLEN +: XLEN];
      end
      assign rf_flat[r*XLEN +: XLEN] = q;
    end
  end

  rfp_read_port #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) rpa_i (
    .rf_flat_i  (rf_flat),
    .idx_i      (ra_idx_i),
    .wid_i      (ra_wid_i),
    .data_o     (ra_data_o),
    .misalign_o (ra_misalign_o)
  );

  rfp_read_port #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) rpb_i (
    .rf_flat_i  (rf_flat),
    .idx_i      (rb_idx_i),
    .wid_i      (rb_wid_i),
    .data_o     (rb_data_o),
    .misalign_o (rb_misalign_o)
  );
endmodule

// File: rtl/rfp_regfile_chk.sv
module rfp_regfile_chk
  import rfp_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int IDX_W = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [IDX_W-1:0]      ra_idx_i,
  input logic [1:0]            ra_wid_i,
  input logic [OP_W-1:0]       ra_data_o,
  input logic                  ra_misalign_o,
  input logic [IDX_W-1:0]      rb_idx_i,
  input logic [1:0]            rb_wid_i,
  input logic [OP_W-1:0]       rb_data_o,
  input logic                  rb_misalign_o,
  input logic                  we_i,
  input logic [IDX_W-1:0]      wr_idx_i,
  input logic [1:0]            wr_wid_i,
  input logic [OP_W-1:0]       wr_data_i,
  input logic                  wr_misalign_o,
  input logic [NREGS*XLEN-1:0] rf_flat
);
  function automatic logic [XLEN-1:0] rf_word(input logic [NREGS*XLEN-1:0] f,
                                              input logic [IDX_W-1:0] i);
    return f[int'(i)*XLEN +: XLEN];
  endfunction

  function automatic logic [XLEN-1:0] lo_word(input logic [OP_W-1:0] d);
    return d[XLEN-1:0];
  endfunction

  a_r1_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_wid_i == WID_SGL && wr_idx_i != '0) |=>
      (rf_word(rf_flat, $past(wr_idx_i)) == lo_word($past(wr_data_i))));

  a_r2_zero_reads_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_wid_i == WID_SGL && ra_idx_i == '0) |-> (ra_data_o == '0));

  a_r12_zero_reads_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_wid_i == WID_SGL && rb_idx_i == '0) |-> (rb_data_o == '0));

  a_r4_flagged_read_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_misalign_o |-> (ra_data_o == '0));

  a_r12_flagged_read_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_misalign_o |-> (rb_data_o == '0));

  a_r7_zero_group_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_idx_i == '0 && wr_wid_i != WID_SGL) |=> $stable(rf_flat));

  a_r8_flagged_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_misalign_o |=> $stable(rf_flat));

  a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rf_flat));

  a_r9_reserved_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ra_wid_i == WID_RSV) |-> ra_misalign_o) and
    ((rb_wid_i == WID_RSV) |-> rb_misalign_o) and
    ((wr_wid_i == WID_RSV) |-> wr_misalign_o));
endmodule

bind rfp_regfile rfp_regfile_chk #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ra_idx_i      (ra_idx_i),
  .ra_wid_i      (ra_wid_i),
  .ra_data_o     (ra_data_o),
  .ra_misalign_o (ra_misalign_o),
  .rb_idx_i      (rb_idx_i),
  .rb_wid_i      (rb_wid_i),
  .rb_data_o     (rb_data_o),
  .rb_misalign_o (rb_misalign_o),
  .we_i          (we_i),
  .wr_idx_i      (wr_idx_i),
  .wr_wid_i      (wr_wid_i),
  .wr_data_i     (wr_data_i),
  .wr_misalign_o (wr_misalign_o),
  .rf_flat       (rf_flat)
);

// File: tb/rfp_regfile_tb_top.sv
`timescale 1ns/1ps
module rfp_regfile_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [4:0]   ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [1:0]   ra_wid = '0, rb_wid = '0, wr_wid = '0;
  logic         we = 1'b0;
  logic [127:0] wr_data = '0;

  logic [127:0] ra_d32, rb_d32, ra_d64, rb_d64;
  logic         ra_m32, rb_m32, wr_m32, ra_m64, rb_m64, wr_m64;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rfp_regfile #(.XLEN(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ra_idx_i(ra_idx), .ra_wid_i(ra_wid), .ra_data_o(ra_d32), .ra_misalign_o(ra_m32),
    .rb_idx_i(rb_idx), .rb_wid_i(rb_wid), .rb_data_o(rb_d32), .rb_misalign_o(rb_m32),
    .we_i(we), .wr_idx_i(wr_idx), .wr_wid_i(wr_wid), .wr_data_i(wr_data),
    .wr_misalign_o(wr_m32)
  );

  rfp_regfile #(.XLEN(64)) dut64_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ra_idx_i(ra_idx), .ra_wid_i(ra_wid), .ra_data_o(ra_d64), .ra_misalign_o(ra_m64),
    .rb_idx_i(rb_idx), .rb_wid_i(rb_wid), .rb_data_o(rb_d64), .rb_misalign_o(rb_m64),
    .we_i(we), .wr_idx_i(wr_idx), .wr_wid_i(wr_wid), .wr_data_i(wr_data),
    .wr_misalign_o(wr_m64)
  );

  typedef struct packed {
    logic [23:0]  tag;
    logic         we;
    logic [4:0]   widx;
    logic [1:0]   wwid;
    logic [127:0] wdat;
    logic [4:0]   ridx;
    logic [1:0]   rwid;
    logic [127:0] exp;
    logic         rmis;
    logic         wmis;
  } vec_t;

  localparam logic [127:0] ONES = {4{32'hFFFF_FFFF}};
  localparam logic [127:0] QV   = 128'h4444_4444_3333_3333_2222_2222_1111_1111;

  // rows: tag, we, widx, wwid, wdat, ridx, rwid, expected read, read flag, write flag
  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{"R1",  1'b1, 5'd5,  2'd0, 128'hA5A5_0005, 5'd5,  2'd0, 128'h0, 1'b0, 1'b0},
    '{"R1",  1'b0, 5'd0,  2'd0, 128'h0,         5'd5,  2'd0, 128'hA5A5_0005, 1'b0, 1'b0},
    '{"R3",  1'b1, 5'd14, 2'd1, 128'h1111_2222_3333_4444, 5'd14, 2'd1, 128'h0, 1'b0, 1'b0},
    '{"R3",  1'b0, 5'd0,  2'd0, 128'h0, 5'd14, 2'd0, 128'h3333_4444, 1'b0, 1'b0},
    '{"R3",  1'b0, 5'd0,  2'd0, 128'h0, 5'd15, 2'd0, 128'h1111_2222, 1'b0, 1'b0},
    '{"R4",  1'b1, 5'd15, 2'd1, ONES,   5'd15, 2'd1, 128'h0, 1'b1, 1'b1},
    '{"R8",  1'b0, 5'd0,  2'd0, 128'h0, 5'd14, 2'd1, 128'h1111_2222_3333_4444, 1'b0, 1'b0},
    '{"R8",  1'b0, 5'd0,  2'd0, 128'h0, 5'd16, 2'd0, 128'h0, 1'b0, 1'b0},
    '{"R1",  1'b1, 5'd1,  2'd0, 128'hCAFE_0001, 5'd1, 2'd0, 128'h0, 1'b0, 1'b0},
    '{"R7",  1'b1, 5'd0,  2'd1, 128'hDEAD_BEEF_1234_5678, 5'd1, 2'd0, 128'hCAFE_0001, 1'b0, 1'b0},
    '{"R7",  1'b0, 5'd0,  2'd0, 128'h0, 5'd1,  2'd0, 128'hCAFE_0001, 1'b0, 1'b0},
    '{"R6",  1'b0, 5'd0,  2'd0, 128'h0, 5'd0,  2'd1, 128'hCAFE_0001_0000_0000, 1'b0, 1'b0},
    '{"R5",  1'b1, 5'd8,  2'd2, QV,     5'd8,  2'd2, 128'h0, 1'b0, 1'b0},
    '{"R5",  1'b0, 5'd0,  2'd0, 128'h0, 5'd8,  2'd2, QV, 1'b0, 1'b0},
    '{"R5",  1'b0, 5'd0,  2'd0, 128'h0, 5'd10, 2'd0, 128'h3333_3333, 1'b0, 1'b0},
    '{"R3",  1'b0, 5'd0,  2'd0, 128'h0, 5'd10, 2'd1, 128'h4444_4444_3333_3333, 1'b0, 1'b0},
    '{"R5",  1'b1, 5'd6,  2'd2, ONES,   5'd6,  2'd2, 128'h0, 1'b1, 1'b1},
    '{"R8",  1'b0, 5'd0,  2'd0, 128'h0, 5'd6,  2'd1, 128'h0, 1'b0, 1'b0},
    '{"R8",  1'b0, 5'd0,  2'd0, 128'h0, 5'd8,  2'd1, 128'h2222_2222_1111_1111, 1'b0, 1'b0},
    '{"R6",  1'b1, 5'd0,  2'd0, 128'hFFFF_FFFF, 5'd0, 2'd2, 128'hCAFE_0001_0000_0000, 1'b0, 1'b0},
    '{"R2",  1'b0, 5'd0,  2'd0, 128'h0, 5'd0,  2'd0, 128'h0, 1'b0, 1'b0},
    '{"R9",  1'b1, 5'd20, 2'd3, ONES,   5'd4,  2'd3, 128'h0, 1'b1, 1'b1},
    '{"R9",  1'b0, 5'd0,  2'd0, 128'h0, 5'd20, 2'd0, 128'h0, 1'b0, 1'b0},
    '{"R3",  1'b1, 5'd30, 2'd1, 128'h7777_0000_8888_0000, 5'd30, 2'd1, 128'h0, 1'b0, 1'b0},
    '{"R3",  1'b0, 5'd0,  2'd0, 128'h0, 5'd30, 2'd1, 128'h7777_0000_8888_0000, 1'b0, 1'b0},
    '{"R5",  1'b1, 5'd31, 2'd0, 128'h1, 5'd28, 2'd2,
      128'h7777_0000_8888_0000_0000_0000_0000_0000, 1'b0, 1'b0},
    '{"R5",  1'b0, 5'd0,  2'd0, 128'h0, 5'd28, 2'd2,
      128'h0000_0001_8888_0000_0000_0000_0000_0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [4:0] wi, input logic [1:0] ww,
                       input logic [127:0] wd, input logic [4:0] ai, input logic [1:0] aw,
                       input logic [4:0] bi, input logic [1:0] bw);
    @(negedge clk);
    we = w; wr_idx = wi; wr_wid = ww; wr_data = wd;
    ra_idx = ai; ra_wid = aw; rb_idx = bi; rb_wid = bw;
    #1;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R11", "reset read", ra_d32, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("%s", VECS[i].tag);
      drive(VECS[i].we, VECS[i].widx, VECS[i].wwid, VECS[i].wdat,
            VECS[i].ridx, VECS[i].rwid, VECS[i].ridx, VECS[i].rwid);
      chk(t, $sformatf("row %0d ra data", i), ra_d32, VECS[i].exp);
      chk(t, $sformatf("row %0d ra flag", i), {127'd0, ra_m32}, {127'd0, VECS[i].rmis});
      // R12: port B mirrors port A
      chk("R12", $sformatf("row %0d rb data", i), rb_d32, VECS[i].exp);
      chk("R12", $sformatf("row %0d rb flag", i), {127'd0, rb_m32}, {127'd0, VECS[i].rmis});
      chk(t, $sformatf("row %0d wr flag", i), {127'd0, wr_m32}, {127'd0, VECS[i].wmis});
    end

    // R12: ports read different registers in the same cycle
    drive(1'b0, 5'd0, 2'd0, '0, 5'd14, 2'd1, 5'd8, 2'd2);
    chk("R12", "split ra", ra_d32, 128'h1111_2222_3333_4444);
    chk("R12", "split rb", rb_d32, QV);

    // R11: asynchronous reset clears contents
    @(negedge clk);
    we = 1'b0; rst_n = 1'b0;
    #1;
    chk("R11", "cleared pair", ra_d32, 128'h0);
    chk("R11", "cleared quad", rb_d32, 128'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: 64-bit build
    drive(1'b1, 5'd3, 2'd0, 128'h0123_4567_89AB_CDEF, 5'd3, 2'd1, 5'd3, 2'd2);
    chk("R10", "dbl odd legal on 64", {127'd0, ra_m64}, 128'h0);
    chk("R10", "quad odd flagged on 64", {127'd0, rb_m64}, 128'h1);
    drive(1'b0, 5'd0, 2'd0, '0, 5'd3, 2'd1, 5'd3, 2'd2);
    chk("R10", "dbl is one reg", ra_d64, 128'h0123_4567_89AB_CDEF);
    chk("R10", "flagged quad zero", rb_d64, 128'h0);
    drive(1'b1, 5'd2, 2'd2, {64'hAAAA_AAAA_AAAA_AAAA, 64'hBBBB_BBBB_BBBB_BBBB},
          5'd0, 2'd0, 5'd0, 2'd0);
    chk("R10", "quad pair write legal", {127'd0, wr_m64}, 128'h0);
    chk("R5", "quad at 2 flagged on 32", {127'd0, wr_m32}, 128'h1);
    drive(1'b0, 5'd0, 2'd0, '0, 5'd3, 2'd0, 5'd2, 2'd0);
    chk("R10", "high reg of pair", ra_d64, 128'hAAAA_AAAA_AAAA_AAAA);
    chk("R10", "low reg of pair", rb_d64, 128'hBBBB_BBBB_BBBB_BBBB);
    drive(1'b1, 5'd0, 2'd2, ONES, 5'd0, 2'd0, 5'd0, 2'd0);
    drive(1'b0, 5'd0, 2'd0, '0, 5'd1, 2'd0, 5'd0, 2'd2);
    chk("R7", "x1 kept on 64", ra_d64, 128'h0);
    chk("R6", "quad at 0 on 64", rb_d64, 128'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule